// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract Long Accumulator

This unit takes two 32-bit operands, each packing two signed 16-bit halves, together with a 64-bit running value supplied as separate upper and lower words. It multiplies the low halves of the two operands and the high halves of the two operands, subtracts the high-half product from the low-half product, and adds that difference to the 64-bit running value. The sum comes back as an upper and a lower word. A swap control exchanges the two halves of the second operand before the multiplies. The cross terms then become low-by-high and high-by-low.

Operations enter on a valid/ready handshake. The registered result appears one clock later with a result-valid strobe, and it stays put until the consumer takes it. Overflow can only arise in the final 64-bit addition. It is not reported, and the sum simply wraps.

A separate combinational decoder inspects a 32-bit instruction word. It reports whether the word fits either of two fixed encodings of this operation, and if so it returns the swap bit taken from that encoding.

Top module: `dmsl_unit`

## Requirements
- R1: With swap low, the added term is N[15:0]*M[15:0] minus N[31:16]*M[31:16], where every half is treated as signed two's complement.
- R2: The result is {acc_hi,acc_lo} plus the product difference, returned as res_hi = sum[63:32] and res_lo = sum[31:0].
- R3: With swap high, M is used as {M[15:0],M[31:16]}, so the term becomes N[15:0]*M[31:16] minus N[31:16]*M[15:0].
- R4: The 64-bit sum wraps modulo 2^64 in both directions and produces no flag.
- R5: The product difference is sign-extended to 64 bits, so negative and full-range differences such as 0x7FFF8000 are exact.
- R6: An operation accepted while in_valid and in_ready are both high at a clock edge appears after that edge with out_valid high. While out_valid is high and out_ready is low, out_valid, res_hi and res_lo hold their values.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: A synchronous active-high reset clears out_valid, res_hi and res_lo.
- R9: A compact-layout word has bits [31:20] = 0xFBD and bits [7:5] = 3'b110. For such a word, dec_match is 1 and dec_swap equals bit 4.
- R10: A conditional-layout word has bits [27:20] = 0x74, bits [7:6] = 2'b01 and bit 4 = 1, with bits [31:28] ignored. For such a word, dec_match is 1 and dec_swap equals bit 5.
- R11: A word that fits neither layout gives dec_match = 0 and dec_swap = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Unit can take operands this cycle |
| op_n | input | 32 | First operand, two signed halves |
| op_m | input | 32 | Second operand, two signed halves |
| swap | input | 1 | Exchange the halves of op_m |
| acc_hi | input | 32 | Upper word of the running value |
| acc_lo | input | 32 | Lower word of the running value |
| out_valid | output | 1 | Result is held on res_hi/res_lo |
| out_ready | input | 1 | Consumer takes the result |
| res_hi | output | 32 | Upper word of the sum |
| res_lo | output | 32 | Lower word of the sum |
| dec_word | input | 32 | Instruction word to classify |
| dec_match | output | 1 | Word fits one of the two layouts |
| dec_swap | output | 1 | Swap bit of the matching layout |

## Verification
The hardest case to reach from the ports is a difference whose magnitude is close to 2^31. This needs both halves at -32768 against a +32767 partner, and only such a difference shows whether the sign extension is correct. The vector table places these extreme halves in both swap settings. It also includes sums that wrap across the 64-bit boundary in each direction and a carry out of the lower word. A directed phase then holds out_ready low while a second operation waits, so that the result under backpressure must stay unchanged.

// File: rtl/dmsl_pkg.sv
`timescale 1ns/1ps
package dmsl_pkg;
   // compact layout: fixed fields, swap bit position
   localparam logic [11:0] CMP_HEAD    = 12'hFBD;
   localparam logic [2:0]  CMP_TAIL    = 3'b110;
   localparam int          CMP_SWAPBIT = 4;
   // conditional layout: fixed fields, swap bit position
   localparam logic [7:0]  CND_HEAD    = 8'h74;
   localparam logic [1:0]  CND_TAIL    = 2'b01;
   localparam int          CND_SWAPBIT = 5;

   typedef enum logic [1:0] {
      LAY_NONE    = 2'd0,
      LAY_COMPACT = 2'd1,
      LAY_COND    = 2'd2
   } layout_e;
endpackage

// File: rtl/dmsl_halfmul.sv
`timescale 1ns/1ps
module dmsl_halfmul #(
   parameter int HALF_W = 16
) (
   input  logic signed [HALF_W-1:0]   a,
   input  logic signed [HALF_W-1:0]   b,
   output logic signed [2*HALF_W-1:0] p
);
   localparam int PROD_W = 2 * HALF_W;

   initial begin
      if (HALF_W < 2) $fatal(1, "dmsl_halfmul: HALF_W must be at least 2");
   end

   always_comb begin
      p = PROD_W'(a * b);
   end
endmodule

// File: rtl/dmsl_layout_dec.sv
`timescale 1ns/1ps
module dmsl_layout_dec
   import dmsl_pkg::*;
(
   input  logic [31:0] word,
   output logic        match,
   output logic        swap_bit,
   output layout_e     layout
);
   logic hit_cmp;
   logic hit_cnd;

   always_comb begin
      hit_cmp = (word[31:20] == CMP_HEAD) && (word[7:5] == CMP_TAIL);
      hit_cnd = (word[27:20] == CND_HEAD) && (word[7:6] == CND_TAIL) && word[4];
      if (hit_cmp) begin
         layout   = LAY_COMPACT;
         swap_bit = word[CMP_SWAPBIT];
      end else if (hit_cnd) begin
         layout   = LAY_COND;
         swap_bit = word[CND_SWAPBIT];
      end else begin
         layout   = LAY_NONE;
         swap_bit = 1'b0;
      end
      match = (layout != LAY_NONE);
   end

   // R11: no swap bit is reported for a word that fits no layout
   always_comb begin
      a_r11_no_swap_unmatched: assert (match || !swap_bit);
   end
endmodule

// File: rtl/dmsl_diffacc.sv
`timescale 1ns/1ps
module dmsl_diffacc #(
   parameter int WORD_W = 32
) (
   input  logic signed [WORD_W-1:0]   prod_lo,
   input  logic signed [WORD_W-1:0]   prod_hi,
   input  logic        [2*WORD_W-1:0] acc,
   output logic        [2*WORD_W-1:0] sum
);
   localparam int ACC_W = 2 * WORD_W;

   logic [ACC_W-1:0] ext_lo;
   logic [ACC_W-1:0] ext_hi;

   always_comb begin
      ext_lo = {{WORD_W{prod_lo[WORD_W-1]}}, prod_lo};
      ext_hi = {{WORD_W{prod_hi[WORD_W-1]}}, prod_hi};
      sum    = acc + (ext_lo - ext_hi);
   end
endmodule

// File: rtl/dmsl_unit.sv
`timescale 1ns/1ps
module dmsl_unit #(
   parameter int HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [2*HALF_W-1:0]   op_n,
   input  logic [2*HALF_W-1:0]   op_m,
   input  logic                  swap,
   input  logic [2*HALF_W-1:0]   acc_hi,
   input  logic [2*HALF_W-1:0]   acc_lo,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [2*HALF_W-1:0]   res_hi,
   output logic [2*HALF_W-1:0]   res_lo,
   input  logic [31:0]           dec_word,
   output logic                  dec_match,
   output logic                  dec_swap
);
   import dmsl_pkg::*;

   localparam int WORD_W = 2 * HALF_W;
   localparam int ACC_W  = 2 * WORD_W;
   localparam int LANES  = 2;

   initial begin
      if (HALF_W < 2) $fatal(1, "dmsl_unit: HALF_W must be at least 2");
   end

   logic [WORD_W-1:0]        m_sel;
   logic signed [WORD_W-1:0] prod [LANES];
   logic [ACC_W-1:0]         sum;
   logic                     take;
   layout_e                  dec_layout;

   assign m_sel = swap ? {op_m[HALF_W-1:0], op_m[WORD_W-1:HALF_W]} : op_m;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dmsl_halfmul #(.HALF_W(HALF_W)) u_mul (
         .a (op_n[g*HALF_W +: HALF_W]),
         .b (m_sel[g*HALF_W +: HALF_W]),
         .p (prod[g])
      );
   end

   dmsl_diffacc #(.WORD_W(WORD_W)) u_acc (
      .prod_lo (prod[0]),
      .prod_hi (prod[1]),
      .acc     ({acc_hi, acc_lo}),
      .sum     (sum)
   );

   dmsl_layout_dec u_dec (
      .word     (dec_word),
      .match    (dec_match),
      .swap_bit (dec_swap),
      .layout   (dec_layout)
   );

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         res_hi    <= '0;
         res_lo    <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         res_hi    <= sum[ACC_W-1:WORD_W];
         res_lo    <= sum[WORD_W-1:0];
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R6: an accepted operation is presented on the next cycle
   a_r6_latency: assert property (@(posedge clk) disable iff (rst)
      take |=> out_valid);
   // R6: a result that has not been taken stays unchanged
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(res_hi) && $stable(res_lo)));
   // R7: a stalled result blocks new operands
   a_r7_stall: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);
   // R2: zero first operand returns the running value unchanged
   a_r2_zero_n: assert property (@(posedge clk) disable iff (rst)
      (take && op_n == '0) |=> ({res_hi, res_lo} == $past({acc_hi, acc_lo})));
   // R8: the first cycle after reset shows no result
   a_r8_after_reset: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && res_hi == '0 && res_lo == '0));
endmodule

// File: tb/dmsl_unit_test.sv
`timescale 1ns/1ps
module dmsl_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] op_n = '0;
   logic [31:0] op_m = '0;
   logic        swap = 1'b0;
   logic [31:0] acc_hi = '0;
   logic [31:0] acc_lo = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] res_hi;
   logic [31:0] res_lo;
   logic [31:0] dec_word = '0;
   logic        dec_match;
   logic        dec_swap;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dmsl_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .op_n(op_n), .op_m(op_m), .swap(swap), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .out_valid(out_valid), .out_ready(out_ready), .res_hi(res_hi), .res_lo(res_lo),
      .dec_word(dec_word), .dec_match(dec_match), .dec_swap(dec_swap)
   );

   // vector: {n, m, swap, acc}
   localparam int NV = 8;
   localparam logic [128:0] VEC [NV] = '{
      {32'h0003_0005, 32'h0007_0002, 1'b0, 64'd100},
      {32'h0003_0005, 32'h0007_0002, 1'b1, 64'd100},
      {32'hFFFF_FFFE, 32'h0003_0004, 1'b0, 64'd0},
      {32'h8000_8000, 32'h7FFF_8000, 1'b0, 64'd0},
      {32'h0000_0001, 32'h0000_0002, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
      {32'h0001_0000, 32'h0001_0000, 1'b0, 64'd0},
      {32'h0000_0001, 32'h0000_0001, 1'b0, 64'h0000_0000_FFFF_FFFF},
      {32'h8000_7FFF, 32'h8000_7FFF, 1'b1, 64'h1234_5678_9ABC_DEF0}
   };
   localparam logic [63:0] EXPV [NV] = '{
      64'd89, 64'd129, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0000_0000_7FFF_8000,
      64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000,
      64'h1234_5678_9ABC_DEF0
   };

   function automatic logic [63:0] model(input logic [31:0] n, input logic [31:0] m,
                                         input logic x, input logic [63:0] acc);
      logic [31:0] mm;
      longint p1, p2;
      mm = x ? {m[15:0], m[31:16]} : m;
      p1 = longint'($signed(n[15:0])) * longint'($signed(mm[15:0]));
      p2 = longint'($signed(n[31:16])) * longint'($signed(mm[31:16]));
      return acc + 64'(p1) - 64'(p2);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] n, input logic [31:0] m, input logic x,
                         input logic [63:0] acc, output logic v, output logic [63:0] got);
      @(negedge clk);
      op_n = n; op_m = m; swap = x; {acc_hi, acc_lo} = acc;
      in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk); #1;
      v = out_valid; got = {res_hi, res_lo};
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic dec_chk(input string req, input logic [31:0] w, input logic em, input logic es);
      dec_word = w; #1;
      chk(req, {62'd0, dec_match, dec_swap}, {62'd0, em, es});
   endtask

   initial begin
      #(4 * 50000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic        v;
      logic [63:0] got;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      // R8 reset state, R7 ready when empty
      chk("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R8 reset result", {res_hi, res_lo}, 64'd0);
      chk("R7 ready when empty", {63'd0, in_ready}, 64'd1);

      // vector table: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][128:97], VEC[i][96:65], VEC[i][64], VEC[i][63:0], v, got);
         chk($sformatf("R6 valid vec %0d", i), {63'd0, v}, 64'd1);
         chk($sformatf("R1 R2 R3 R4 R5 vec %0d model", i), got,
             model(VEC[i][128:97], VEC[i][96:65], VEC[i][64], VEC[i][63:0]));
         chk($sformatf("R2 vec %0d table", i), got, EXPV[i]);
      end

      // R6 drop of valid once taken with no new input
      @(posedge clk); #1;
      chk("R6 valid cleared after take", {63'd0, out_valid}, 64'd0);

      // R6/R7 backpressure
      @(negedge clk);
      op_n = 32'h0003_0005; op_m = 32'h0007_0002; swap = 1'b0; {acc_hi, acc_lo} = 64'd100;
      in_valid = 1'b1; out_ready = 1'b0;
      @(negedge clk);
      op_n = 32'h0001_0000; op_m = 32'h0001_0000; {acc_hi, acc_lo} = 64'd0;
      chk("R7 stalled not ready", {63'd0, in_ready}, 64'd0);
      repeat (2) @(posedge clk);
      #1;
      chk("R6 held valid", {63'd0, out_valid}, 64'd1);
      chk("R6 held result", {res_hi, res_lo}, 64'd89);
      @(negedge clk); out_ready = 1'b1; #1;
      chk("R7 ready when taken", {63'd0, in_ready}, 64'd1);
      @(posedge clk); #1;
      chk("R6 second result after release", {res_hi, res_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
      @(posedge clk); #1;
      // R8 reset mid-run while a result is held
      chk("R6 held before reset", {63'd0, out_valid}, 64'd1);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      chk("R8 reset clears valid", {63'd0, out_valid}, 64'd0);
      chk("R8 reset clears result", {res_hi, res_lo}, 64'd0);
      @(negedge clk); rst = 1'b0; out_ready = 1'b1;

      // decoder R9 R10 R11
      dec_chk("R9 compact swap0", 32'hFBD3_21C5, 1'b1, 1'b0);
      dec_chk("R9 compact swap1", 32'hFBD3_21D5, 1'b1, 1'b1);
      dec_chk("R10 cond swap0", 32'hE741_2350, 1'b1, 1'b0);
      dec_chk("R10 cond field ignored swap1", 32'h0741_2370, 1'b1, 1'b1);
      dec_chk("R11 cond bit4 clear", 32'hE741_2340, 1'b0, 1'b0);
      dec_chk("R11 compact tail wrong", 32'hFBD3_21F5, 1'b0, 1'b0);
      dec_chk("R11 zero word", 32'h0000_0000, 1'b0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule